// File: doc/BRIEF.md
# Protection Alert and Fault Engine

This block watches sixteen independent protection quantities (cell voltages, current magnitudes, temperatures, diagnostic deviations and a host-silence timer) and turns each one into a two-stage response. When a sampled value first goes past its programmed limit, the check raises an early warning, the alert. If the value keeps breaking the limit for a programmed number of further samples, the warning is promoted to a latched fault. The fault stays set until a sample comes back inside the limit by a programmed margin. Measurement, analog comparators and the host bus sit outside the block. A comparator trip is fed in as a value that lies above its threshold.

Each check is a small state machine with three states. CHK_IDLE means the check is quiet. CHK_ALERT means an excursion has been seen and its length is being counted. CHK_FAULT means the fault is latched. The transitions are TRIP (idle to alert, on an excursion sample when the delay is non-zero), PROMOTE (to fault, either from alert once the count is reached or straight from idle when the delay is zero), ABANDON (alert to idle, on an in-limit sample), RECOVER (fault to idle, on a sample inside the hysteresis band) and DISABLE (any state to idle when the enable bit drops). The block packs the alerts and faults into two alert bytes and two status bytes, and it also gives the raw fault vector.

Check index i is bit i of `fault_vec`. Indices 15..8 are status byte A, bits 7..0. Indices 7..0 are status byte B, bits 7..0.

Top module: `prot_engine`

## Requirements
- R1: While reset is asserted, and after it is released, every output reads zero until a strobed sample changes a check.
- R2: With a non-zero delay, the first strobed excursion sample sets the check's alert bit in the next cycle. High-trip checks are excursions when value > threshold. The low-trip checks are indices 14 (cell undervoltage), 5 (discharge undertemperature) and 4 (charge undertemperature), and they are excursions when value < threshold.
- R3: With delay D, the fault bit sets on the (D+1)-th consecutive strobed excursion sample. In the same cycle the alert bit clears. With D = 0 the fault sets on the first excursion sample and no alert is seen.
- R4: A value change without its sample strobe has no effect on any output.
- R5: A strobed in-limit sample taken in the alert state clears the alert and restarts the count, so the next excursion needs D+1 samples again.
- R6: A latched fault clears only on a strobed sample inside the margin. For a high-trip check that means value + hysteresis < threshold. For a low-trip check it means value > threshold + hysteresis. Samples between the limit and the margin keep the fault set.
- R7: Clearing a check's enable bit clears its alert, its fault and its count in the next cycle, whatever the samples are doing. Enable bits enable_a[7:0] govern indices 15..8 and enable_b[7:0] govern indices 7..0.
- R8: Alert byte A holds overvoltage in bit 7, undervoltage in bit 6, short circuit in bit 5, discharge overcurrent 1 in bit 4, discharge overcurrent 2 in bit 3 and charge overcurrent in bit 2. Its bits 1 and 0 always read zero. Status byte A uses the same six bits, adds the current-latch fault (index 9) in bit 1 and the regulator fault (index 8) in bit 0.
- R9: Alert byte B and status byte B both map discharge overtemperature to bit 7, charge overtemperature to bit 6, discharge undertemperature to bit 5, charge undertemperature to bit 4, internal overtemperature to bit 3, host watchdog to bit 2, reference diagnostic to bit 1 and ground diagnostic to bit 0.
- R10: Checks are independent: activity or disabling on one index leaves every other index's alert and fault unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable_a | input | 8 | Enables for checks 15..8 |
| enable_b | input | 8 | Enables for checks 7..0 |
| sample_valid | input | 16 | Per-check sample strobe, one cycle per new value |
| values | input | 16*VAL_W | Monitored values, check i at [i*VAL_W +: VAL_W] |
| thresholds | input | 16*VAL_W | Trip thresholds, same packing |
| delays | input | 16*DLY_W | Extra excursion samples before promotion |
| hysts | input | 16*HYS_W | Recovery margins |
| alert_a | output | 8 | Alert byte A |
| alert_b | output | 8 | Alert byte B |
| status_a | output | 8 | Status byte A |
| status_b | output | 8 | Status byte B |
| fault_vec | output | 16 | Fault per check index |

## Verification
A check stuck in the wrong state shows at the ports in the cycle after the strobed sample that should have moved it. If an alert fails to promote, its alert bit stays set where the status bit should appear. If a fault releases early, it drops on a sample inside the hysteresis band. If a count is off by one, promotion happens one sample early or late. Wrong bit packing shows at once as the wrong byte value, and a stale count left after an abandoned excursion shows as a premature fault on the next run of excursions.

// File: rtl/prot_pkg.sv
package prot_pkg;
    localparam int NUM_CHECKS = 16;
    // Checks that trip when the value falls below the threshold
    localparam logic [NUM_CHECKS-1:0] LOW_TRIP_MASK = 16'h4030;

    typedef enum logic [1:0] {
        CHK_IDLE  = 2'd0,
        CHK_ALERT = 2'd1,
        CHK_FAULT = 2'd2
    } chk_state_e;
endpackage

// File: rtl/prot_check.sv
module prot_check
    import prot_pkg::*;
#(
    parameter int  VAL_W    = 12,
    parameter int  DLY_W    = 8,
    parameter int  HYS_W    = 8,
    parameter bit  LOW_TRIP = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             sample_valid,
    input  logic [VAL_W-1:0] value,
    input  logic [VAL_W-1:0] threshold,
    input  logic [DLY_W-1:0] delay,
    input  logic [HYS_W-1:0] hyst,
    output logic             alert,
    output logic             fault
);
    localparam int EXT_W = VAL_W + 1;

    chk_state_e      state_q, state_d;
    logic [DLY_W-1:0] cnt_q, cnt_d;
    logic            beyond;
    logic            recovered;
    logic [EXT_W-1:0] val_ext, thr_ext, hys_ext;
    logic [DLY_W:0]  cnt_next;

    assign val_ext  = {1'b0, value};
    assign thr_ext  = {1'b0, threshold};
    assign hys_ext  = {{(EXT_W-HYS_W){1'b0}}, hyst};
    assign cnt_next = {1'b0, cnt_q} + 1'b1;

    generate
        if (LOW_TRIP) begin : g_low
            assign beyond    = value < threshold;
            assign recovered = val_ext > (thr_ext + hys_ext);
        end else begin : g_high
            assign beyond    = value > threshold;
            assign recovered = (val_ext + hys_ext) < thr_ext;
        end
    endgenerate

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CHK_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (!en) begin
            state_d = CHK_IDLE;                 // DISABLE
            cnt_d   = '0;
        end else if (sample_valid) begin
            unique case (state_q)
                CHK_IDLE: begin
                    if (beyond) begin
                        cnt_d = '0;
                        if (delay == '0) state_d = CHK_FAULT;   // PROMOTE
                        else             state_d = CHK_ALERT;   // TRIP
                    end
                end
                CHK_ALERT: begin
                    if (!beyond) begin
                        state_d = CHK_IDLE;                     // ABANDON
                        cnt_d   = '0;
                    end else if (cnt_next >= {1'b0, delay}) begin
                        state_d = CHK_FAULT;                    // PROMOTE
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_next[DLY_W-1:0];
                    end
                end
                CHK_FAULT: begin
                    if (recovered) state_d = CHK_IDLE;          // RECOVER
                end
                default: begin
                    state_d = CHK_IDLE;
                    cnt_d   = '0;
                end
            endcase
        end
    end

    // Outputs
    always_comb begin
        alert = 1'b0;
        fault = 1'b0;
        unique case (state_q)
            CHK_IDLE:  ;
            CHK_ALERT: alert = 1'b1;
            CHK_FAULT: fault = 1'b1;
            default:   ;
        endcase
    end
endmodule

// File: rtl/prot_pack.sv
module prot_pack
    import prot_pkg::*;
(
    input  logic [5:0] alert_hi,   // alerts of indices 15..10
    input  logic [7:0] alert_lo,   // alerts of indices 7..0
    input  logic [NUM_CHECKS-1:0] faults,
    output logic [7:0] alert_a,
    output logic [7:0] alert_b,
    output logic [7:0] status_a,
    output logic [7:0] status_b
);
    assign alert_a  = {alert_hi, 2'b00};
    assign alert_b  = alert_lo;
    assign status_a = faults[15:8];
    assign status_b = faults[7:0];
endmodule

// File: rtl/prot_engine.sv
module prot_engine
    import prot_pkg::*;
#(
    parameter int VAL_W = 12,
    parameter int DLY_W = 8,
    parameter int HYS_W = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [7:0]                  enable_a,
    input  logic [7:0]                  enable_b,
    input  logic [NUM_CHECKS-1:0]       sample_valid,
    input  logic [NUM_CHECKS*VAL_W-1:0] values,
    input  logic [NUM_CHECKS*VAL_W-1:0] thresholds,
    input  logic [NUM_CHECKS*DLY_W-1:0] delays,
    input  logic [NUM_CHECKS*HYS_W-1:0] hysts,
    output logic [7:0]                  alert_a,
    output logic [7:0]                  alert_b,
    output logic [7:0]                  status_a,
    output logic [7:0]                  status_b,
    output logic [NUM_CHECKS-1:0]       fault_vec
);
    logic [NUM_CHECKS-1:0] en_vec;
    logic [NUM_CHECKS-1:0] alert_vec;

    assign en_vec = {enable_a, enable_b};

    generate
        for (genvar i = 0; i < NUM_CHECKS; i++) begin : g_chk
            prot_check #(
                .VAL_W   (VAL_W),
                .DLY_W   (DLY_W),
                .HYS_W   (HYS_W),
                .LOW_TRIP(LOW_TRIP_MASK[i])
            ) u_chk (
                .clk         (clk),
                .rst_n       (rst_n),
                .en          (en_vec[i]),
                .sample_valid(sample_valid[i]),
                .value       (values[i*VAL_W +: VAL_W]),
                .threshold   (thresholds[i*VAL_W +: VAL_W]),
                .delay       (delays[i*DLY_W +: DLY_W]),
                .hyst        (hysts[i*HYS_W +: HYS_W]),
                .alert       (alert_vec[i]),
                .fault       (fault_vec[i])
            );
        end
    endgenerate

    prot_pack u_pack (
        .alert_hi(alert_vec[15:10]),
        .alert_lo(alert_vec[7:0]),
        .faults  (fault_vec),
        .alert_a (alert_a),
        .alert_b (alert_b),
        .status_a(status_a),
        .status_b(status_b)
    );
endmodule

// File: rtl/prot_engine_sva.sv
module prot_engine_sva
    import prot_pkg::*;
(
    input logic                  clk,
    input logic                  rst_n,
    input logic [NUM_CHECKS-1:0] en_vec,
    input logic [NUM_CHECKS-1:0] sample_valid,
    input logic [NUM_CHECKS-1:0] alert_vec,
    input logic [7:0]            alert_a,
    input logic [7:0]            status_a,
    input logic [7:0]            status_b,
    input logic [NUM_CHECKS-1:0] fault_vec
);
    // R1: outputs are zero in the cycle after any reset edge
    a_r1_reset_zero: assert property (@(posedge clk)
        !rst_n |=> (fault_vec == '0 && alert_vec == '0 && status_a == 8'h00 && status_b == 8'h00));

    // R3: a check never shows alert and fault together
    a_r3_alert_fault_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        (alert_vec & fault_vec) == '0);

    // R4: a new fault needs a strobed sample on the previous edge
    a_r4_fault_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((fault_vec & ~$past(fault_vec) & ~$past(sample_valid)) == '0));

    // R4: a new alert needs a strobed sample on the previous edge
    a_r4_alert_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((alert_vec & ~$past(alert_vec) & ~$past(sample_valid)) == '0));

    // R6: an enabled fault only drops after a strobed sample
    a_r6_fault_holds: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((~fault_vec & $past(fault_vec) & $past(en_vec) & ~$past(sample_valid)) == '0));

    // R7: a disabled check is quiet in the following cycle
    a_r7_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((fault_vec | alert_vec) & ~$past(en_vec)) == '0));

    // R8: status byte A follows faults of indices 15..8
    a_r8_status_map: assert property (@(posedge clk) disable iff (!rst_n)
        status_a == fault_vec[15:8] && alert_a[7:2] == alert_vec[15:10]);
endmodule

bind prot_engine prot_engine_sva u_sva (
    .clk         (clk),
    .rst_n       (rst_n),
    .en_vec      (en_vec),
    .sample_valid(sample_valid),
    .alert_vec   (alert_vec),
    .alert_a     (alert_a),
    .status_a    (status_a),
    .status_b    (status_b),
    .fault_vec   (fault_vec)
);

// File: tb/prot_engine_tb.sv
module prot_engine_tb;
    localparam int NC    = 16;
    localparam int VAL_W = 12;
    localparam int DLY_W = 8;
    localparam int HYS_W = 8;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic [7:0]            enable_a = 8'hFF;
    logic [7:0]            enable_b = 8'hFF;
    logic [NC-1:0]         sample_valid = '0;
    logic [NC*VAL_W-1:0]   values = '0;
    logic [NC*VAL_W-1:0]   thresholds = '0;
    logic [NC*DLY_W-1:0]   delays = '0;
    logic [NC*HYS_W-1:0]   hysts = '0;
    logic [7:0]            alert_a, alert_b, status_a, status_b;
    logic [NC-1:0]         fault_vec;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    prot_engine #(.VAL_W(VAL_W), .DLY_W(DLY_W), .HYS_W(HYS_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .enable_a(enable_a), .enable_b(enable_b),
        .sample_valid(sample_valid), .values(values), .thresholds(thresholds),
        .delays(delays), .hysts(hysts), .alert_a(alert_a), .alert_b(alert_b),
        .status_a(status_a), .status_b(status_b), .fault_vec(fault_vec)
    );

    task automatic check(string req, int actual, int expected);
        checks++;
        if (actual != expected) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, actual, expected);
        end
    endtask

    task automatic cfg(int idx, int thr, int dly, int hys);
        thresholds[idx*VAL_W +: VAL_W] = thr[VAL_W-1:0];
        delays[idx*DLY_W +: DLY_W]     = dly[DLY_W-1:0];
        hysts[idx*HYS_W +: HYS_W]      = hys[HYS_W-1:0];
    endtask

    // Drive one strobed sample; return at the following falling edge
    task automatic sample(int idx, int val);
        @(negedge clk);
        values[idx*VAL_W +: VAL_W] = val[VAL_W-1:0];
        sample_valid[idx] = 1'b1;
        @(posedge clk);
        @(negedge clk);
        sample_valid = '0;
    endtask

    task automatic t_reset();
        check("R1 alert_a", alert_a, 0);
        check("R1 alert_b", alert_b, 0);
        check("R1 status_a", status_a, 0);
        check("R1 status_b", status_b, 0);
        check("R1 fault_vec", fault_vec, 0);
    endtask

    task automatic t_overvoltage();
        cfg(15, 100, 2, 10);
        sample(15, 101);
        check("R2 R8 first excursion alert_a", alert_a, 8'h80);
        check("R2 no fault yet", status_a, 0);
        sample(15, 150);
        check("R3 second excursion still alert", alert_a, 8'h80);
        sample(15, 120);
        check("R3 promoted status_a", status_a, 8'h80);
        check("R3 alert dropped", alert_a, 0);
        sample(15, 95);
        check("R6 inside band holds fault", status_a, 8'h80);
        sample(15, 90);
        check("R6 edge of margin holds fault", status_a, 8'h80);
        sample(15, 89);
        check("R6 recovered", status_a, 0);
        // R4: value change without strobe
        @(negedge clk);
        values[15*VAL_W +: VAL_W] = 12'd500;
        repeat (4) @(negedge clk);
        check("R4 unstrobed value ignored alert", alert_a, 0);
        check("R4 unstrobed value ignored fault", fault_vec, 0);
    endtask

    task automatic t_undervoltage();
        cfg(14, 50, 3, 5);
        sample(14, 40);
        check("R2 low-trip alert", alert_a, 8'h40);
        sample(14, 45);
        sample(14, 60);
        check("R5 in-limit sample abandons alert", alert_a, 0);
        sample(14, 40);
        sample(14, 40);
        sample(14, 40);
        check("R5 count restarted, still alert", alert_a, 8'h40);
        check("R5 no early fault", status_a, 0);
        sample(14, 40);
        check("R3 low-trip promotion", status_a, 8'h40);
        sample(14, 55);
        check("R6 low-trip band holds", status_a, 8'h40);
        sample(14, 56);
        check("R6 low-trip recovered", status_a, 0);
    endtask

    task automatic t_bank_b_and_disable();
        cfg(2, 5, 0, 0);
        sample(2, 10);
        check("R3 zero delay fault", status_b, 8'h04);
        check("R3 zero delay no alert", alert_b, 0);
        cfg(5, 30, 1, 0);
        sample(5, 20);
        check("R9 R10 alert_b bit5 with fault bit2 kept", alert_b, 8'h20);
        check("R10 fault bit2 kept", status_b, 8'h04);
        @(negedge clk);
        enable_b[2] = 1'b0;
        @(negedge clk);
        check("R7 disable clears fault", status_b, 0);
        check("R10 other alert unaffected", alert_b, 8'h20);
        enable_b[5] = 1'b0;
        @(negedge clk);
        check("R7 disable clears alert", alert_b, 0);
        enable_b[5] = 1'b1;
        enable_b[2] = 1'b1;
        sample(5, 20);
        check("R7 count cleared by disable", alert_b, 8'h20);
        sample(5, 20);
        check("R9 bit5 fault", status_b, 8'h20);
        cfg(7, 80, 0, 0);
        sample(7, 81);
        check("R9 bit7 fault", status_b, 8'hA0);
        check("R9 fault_vec", fault_vec, 16'h00A0);
    endtask

    task automatic t_reserved();
        cfg(9, 0, 0, 0);
        sample(9, 1);
        check("R8 current latch in status bit1", status_a, 8'h02);
        cfg(8, 0, 1, 0);
        sample(8, 1);
        check("R8 reserved alert bits read zero", alert_a, 0);
        sample(8, 1);
        check("R8 regulator fault in status bit0", status_a, 8'h03);
        cfg(10, 200, 1, 0);
        sample(10, 300);
        check("R8 charge overcurrent alert bit2", alert_a, 8'h04);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_overvoltage();
        t_undervoltage();
        t_bank_b_and_disable();
        t_reserved();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule